// File: doc/BRIEF.md
# Memory Controller Event Counter Bank

The block holds a small set of hardware counters that watch a memory controller. Slot 0 is a free-running cycle counter. Every other slot counts pulses on one line of an event strobe vector, and an 8-bit select code chooses the line. Software controls the bank through a simple 32-bit register bus: each slot has a control word and a read-only count word.

The cycle counter is the master gate. While it is disabled, or after it has wrapped, no slot advances. A wrap of the cycle counter also raises a level interrupt, which tells software to read out and restart the bank. Event slots flag their own overflow without interrupting. A parameter picks the event overflow policy: either the slot wraps and keeps counting, or it holds at its top value until software clears it.

Top module: `evt_cnt_bank`

## Requirements
- R1: After reset every count reads 0, every control word reads 0x00000002 (clear bit 1, all else 0) and irq_o is low.
- R2: The word-aligned byte offset 4·n selects control word n, and 0x20 + 4·n selects count word n. Any other offset, including one with addr[1:0] not 0, reads 0. bus_rdata_o is 0 in every cycle without a read request (bus_req_i high and bus_we_i low).
- R3: Control word fields: bit 0 is the overflow flag, bit 1 is clear, bit 2 is enable, and bits 31:24 are the event select. Bits 23:3 read 0. Writes to bit 0 and writes to count words have no effect.
- R4: The cycle counter (slot 0) goes up by one on each clock while its enable is set and its overflow flag is clear. It ignores its select field.
- R5: Event slot n (n ≥ 1) goes up by one in a cycle where evt_i[select] is high, its own enable is set, and the cycle counter's enable is set with its overflow clear. A select value of EVT_W or more never counts.
- R6: A write to control word 0 that sets the clear bit while the stored clear bit is 0 zeroes the cycle count and its overflow flag. The clear bit keeps the value written.
- R7: A write with clear bit 0 to an event slot's control word zeroes that slot's count and overflow flag. The clear bit reads 0 in the next cycle and then returns to 1 by itself.
- R8: When the cycle counter increments at all ones, it wraps to 0, sets its overflow flag and raises irq_o. After that no slot changes until software acts.
- R9: irq_o is a level. It stays high until slot 0's overflow flag is cleared, either as in R6 or by writing 0 to slot 0's enable bit.
- R10: While slot 0's enable bit is 0, no count in the bank changes except through a clear.
- R11: An event slot that increments at all ones sets its own overflow flag and does not raise irq_o. With WRAP_EVT_OVF=1 it wraps to 0 and keeps counting. With WRAP_EVT_OVF=0 it holds all ones and stops until it is cleared.
- R12: A clear in the same cycle as an increment wins, so the count becomes 0. A new enable or select value takes effect from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Register access request |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from the address |
| evt_i | input | EVT_W | Event strobes, one per line, one count per high cycle |
| irq_o | output | 1 | Cycle counter overflow interrupt, level |

## Verification
The assertions assume that software never writes to the bank while the checked window is open. The freeze properties only apply in cycles with no write, so a restart or a clear is not flagged. Every count is assumed to move by 0 or +1 or to drop to 0, never by any other amount. The stimulus issues each write as one single-cycle request and otherwise scans reads. The counter width is narrowed so that wraps happen within the run, and the bench clears the cycle counter at intervals short enough that long event-overflow phases end before slot 0 can wrap.

// File: rtl/evt_cnt_pkg.sv
package evt_cnt_pkg;
  localparam int DATA_W        = 32;
  localparam int SEL_W         = 8;
  localparam int SEL_LSB       = 24;
  localparam int BIT_OVF       = 0;
  localparam int BIT_CLR       = 1;
  localparam int BIT_EN        = 2;
  localparam int CNT_BASE_WORD = 8;   // count words start at byte 0x20

  // stored per-slot control state
  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic             en;
    logic             clr;
    logic             ovf;
  } ctrl_t;

  // writable control fields
  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic             en;
    logic             clr;
  } wr_fld_t;

  function automatic logic [DATA_W-1:0] ctrl_word(ctrl_t c);
    logic [DATA_W-1:0] w;
    w = '0;
    w[SEL_LSB +: SEL_W] = c.sel;
    w[BIT_EN]  = c.en;
    w[BIT_CLR] = c.clr;
    w[BIT_OVF] = c.ovf;
    return w;
  endfunction
endpackage

// File: rtl/evt_cnt_regs.sv
module evt_cnt_regs
  import evt_cnt_pkg::*;
#(
  parameter int NUM_CNT = 4,
  parameter int CNT_W   = 32,
  parameter int ADDR_W  = 8
) (
  input  logic                            req_i,
  input  logic                            we_i,
  input  logic [ADDR_W-1:0]               addr_i,
  input  ctrl_t [NUM_CNT-1:0]             ctrl_i,
  input  logic  [NUM_CNT-1:0][CNT_W-1:0]  cnt_i,
  output logic  [NUM_CNT-1:0]             ctrl_wr_o,
  output logic  [DATA_W-1:0]              rdata_o
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] word_idx;
  logic             aligned;
  logic             rd_en;

  assign word_idx = addr_i[ADDR_W-1:2];
  assign aligned  = (addr_i[1:0] == 2'b00);
  assign rd_en    = req_i & ~we_i & aligned;

  always_comb begin
    for (int n = 0; n < NUM_CNT; n++)
      ctrl_wr_o[n] = req_i & we_i & aligned & (word_idx == IDX_W'(n));
  end

  always_comb begin
    rdata_o = '0;
    if (rd_en) begin
      for (int n = 0; n < NUM_CNT; n++) begin
        if (word_idx == IDX_W'(n))
          rdata_o = ctrl_word(ctrl_i[n]);
        if (word_idx == IDX_W'(CNT_BASE_WORD + n))
          rdata_o = DATA_W'(cnt_i[n]);
      end
    end
  end
endmodule

// File: rtl/evt_cnt_slice.sv
module evt_cnt_slice
  import evt_cnt_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int EVT_W    = 16,
  parameter bit IS_CYCLE = 1'b0,
  parameter bit WRAP_OVF = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             gate_i,
  input  logic             wr_i,
  input  wr_fld_t          wr_fld_i,
  input  logic [EVT_W-1:0] evt_i,
  output ctrl_t            ctrl_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam bit ROLL = IS_CYCLE | WRAP_OVF;

  logic [CNT_W-1:0] cnt_q;
  logic [SEL_W-1:0] sel_q;
  logic             en_q, clr_q, ovf_q;
  logic             hit, inc, at_max, clr_hit, off_hit;

  generate
    if (IS_CYCLE) begin : g_cyc
      logic unused_evt;
      assign unused_evt = ^evt_i;
      assign hit = 1'b1;
    end else begin : g_evt
      always_comb begin
        hit = 1'b0;
        for (int k = 0; k < EVT_W; k++)
          if (sel_q == SEL_W'(k)) hit = evt_i[k];
      end
    end
  endgenerate

  assign at_max = &cnt_q;
  assign inc    = gate_i & en_q & hit & (ROLL | ~ovf_q);
  // cycle slot clears on a 0->1 of its clear bit, event slots on a written 0
  assign clr_hit = IS_CYCLE ? (wr_i & ~clr_q & wr_fld_i.clr) : (wr_i & ~wr_fld_i.clr);
  assign off_hit = IS_CYCLE & wr_i & ~wr_fld_i.en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
      en_q  <= 1'b0;
      clr_q <= 1'b1;
      sel_q <= '0;
    end else begin
      if (clr_hit) begin
        cnt_q <= '0;
        ovf_q <= 1'b0;
      end else if (inc) begin
        if (at_max) begin
          ovf_q <= 1'b1;
          if (ROLL) cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
      if (off_hit) ovf_q <= 1'b0;
      if (wr_i) begin
        en_q  <= wr_fld_i.en;
        clr_q <= wr_fld_i.clr;
        sel_q <= wr_fld_i.sel;
      end else if (!IS_CYCLE) begin
        clr_q <= 1'b1;
      end
    end
  end

  assign cnt_o = cnt_q;
  always_comb begin
    ctrl_o     = '0;
    ctrl_o.sel = sel_q;
    ctrl_o.en  = en_q;
    ctrl_o.clr = clr_q;
    ctrl_o.ovf = ovf_q;
  end
endmodule

// File: rtl/evt_cnt_bank.sv
module evt_cnt_bank
  import evt_cnt_pkg::*;
#(
  parameter int NUM_CNT      = 4,
  parameter int CNT_W        = 32,
  parameter int EVT_W        = 16,
  parameter int ADDR_W       = 8,
  parameter bit WRAP_EVT_OVF = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic [EVT_W-1:0]  evt_i,
  output logic              irq_o
);
  ctrl_t [NUM_CNT-1:0]            ctrl_w;
  logic  [NUM_CNT-1:0][CNT_W-1:0] cnt_w;
  logic  [NUM_CNT-1:0]            ctrl_wr_w;
  wr_fld_t                        wr_fld_w;
  logic                           cyc_en_w;
  logic                           gate_w;
  logic                           unused_wdata;

  assign wr_fld_w.sel = bus_wdata_i[SEL_LSB +: SEL_W];
  assign wr_fld_w.en  = bus_wdata_i[BIT_EN];
  assign wr_fld_w.clr = bus_wdata_i[BIT_CLR];
  assign unused_wdata = ^{bus_wdata_i[SEL_LSB-1:BIT_EN+1], bus_wdata_i[BIT_OVF]};

  assign cyc_en_w = ctrl_w[0].en;
  assign gate_w   = cyc_en_w & ~ctrl_w[0].ovf;
  assign irq_o    = ctrl_w[0].ovf;

  evt_cnt_regs #(
    .NUM_CNT (NUM_CNT),
    .CNT_W   (CNT_W),
    .ADDR_W  (ADDR_W)
  ) u_regs (
    .req_i     (bus_req_i),
    .we_i      (bus_we_i),
    .addr_i    (bus_addr_i),
    .ctrl_i    (ctrl_w),
    .cnt_i     (cnt_w),
    .ctrl_wr_o (ctrl_wr_w),
    .rdata_o   (bus_rdata_o)
  );

  generate
    for (genvar n = 0; n < NUM_CNT; n++) begin : g_slot
      evt_cnt_slice #(
        .CNT_W    (CNT_W),
        .EVT_W    (EVT_W),
        .IS_CYCLE (n == 0),
        .WRAP_OVF (WRAP_EVT_OVF)
      ) u_slice (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .gate_i   (gate_w),
        .wr_i     (ctrl_wr_w[n]),
        .wr_fld_i (wr_fld_w),
        .evt_i    (evt_i),
        .ctrl_o   (ctrl_w[n]),
        .cnt_o    (cnt_w[n])
      );
    end
  endgenerate
endmodule

// File: rtl/evt_cnt_bank_chk.sv
module evt_cnt_bank_chk #(
  parameter int NUM_CNT = 4,
  parameter int CNT_W   = 32,
  parameter int ADDR_W  = 8
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           bus_req_i,
  input logic                           bus_we_i,
  input logic [ADDR_W-1:0]              bus_addr_i,
  input logic [31:0]                    bus_rdata_o,
  input logic                           irq_o,
  input logic                           cyc_en_i,
  input logic [NUM_CNT-1:0][CNT_W-1:0]  cnt_i
);
  localparam int IDX_W = ADDR_W - 2;

  logic             wr_any, rd_req, undef_off;
  logic [IDX_W-1:0] idx;

  assign wr_any = bus_req_i & bus_we_i;
  assign rd_req = bus_req_i & ~bus_we_i;
  assign idx    = bus_addr_i[ADDR_W-1:2];
  assign undef_off = (bus_addr_i[1:0] != 2'b00) ||
                     ((idx >= IDX_W'(NUM_CNT)) &&
                      !((idx >= IDX_W'(8)) && (idx < IDX_W'(8 + NUM_CNT))));

  p_undef_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req && undef_off) |-> (bus_rdata_o == 32'h0));

  p_idle_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_req |-> (bus_rdata_o == 32'h0));

  p_frozen_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !wr_any) |=> $stable(cnt_i));

  p_irq_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> (&$past(cnt_i[0])));

  p_halt_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cyc_en_i && !wr_any) |=> $stable(cnt_i));

  generate
    for (genvar n = 0; n < NUM_CNT; n++) begin : g_step
      // R4 / R5: at most one step per clock
      p_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((cnt_i[n] == $past(cnt_i[n])) ||
                  (cnt_i[n] == $past(cnt_i[n]) + CNT_W'(1)) ||
                  (cnt_i[n] == '0)));
    end
  endgenerate
endmodule

bind evt_cnt_bank evt_cnt_bank_chk #(
  .NUM_CNT (NUM_CNT),
  .CNT_W   (CNT_W),
  .ADDR_W  (ADDR_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_req_i   (bus_req_i),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .bus_rdata_o (bus_rdata_o),
  .irq_o       (irq_o),
  .cyc_en_i    (cyc_en_w),
  .cnt_i       (cnt_w)
);

// File: tb/sim_evt_cnt_bank.sv
module sim_evt_cnt_bank;
  localparam int CLK_P = 10;
  localparam int NC    = 4;
  localparam int CW    = 8;
  localparam int EW    = 16;
  localparam int MAXV  = (1 << CW) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [EW-1:0] evt = '0;
  logic [31:0] rdata [2];
  logic        irq [2];

  int    n_chk = 0, n_fail = 0;
  string cur_req = "R1";
  int    scan_ptr = 0;

  // reference model state: [instance][slot]
  int       m_cnt [2][NC];
  bit       m_en  [2][NC];
  bit       m_clr [2][NC];
  bit       m_ovf [2][NC];
  bit [7:0] m_sel [2][NC];

  always #(CLK_P/2) clk = ~clk;

  evt_cnt_bank #(.NUM_CNT(NC), .CNT_W(CW), .EVT_W(EW), .ADDR_W(8), .WRAP_EVT_OVF(1'b0)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata[0]), .evt_i(evt), .irq_o(irq[0]));

  evt_cnt_bank #(.NUM_CNT(NC), .CNT_W(CW), .EVT_W(EW), .ADDR_W(8), .WRAP_EVT_OVF(1'b1)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata[1]), .evt_i(evt), .irq_o(irq[1]));

  task automatic model_reset();
    for (int i = 0; i < 2; i++)
      for (int n = 0; n < NC; n++) begin
        m_cnt[i][n] = 0; m_en[i][n] = 0; m_clr[i][n] = 1; m_ovf[i][n] = 0; m_sel[i][n] = 0;
      end
  endtask

  function automatic logic [31:0] model_read(int i);
    int widx;
    if (!(req && !we) || addr[1:0] != 2'b00) return 32'h0;
    widx = int'(addr[7:2]);
    if (widx < NC)
      return {m_sel[i][widx], 21'h0, m_en[i][widx], m_clr[i][widx], m_ovf[i][widx]};
    if (widx >= 8 && widx < 8 + NC)
      return 32'(m_cnt[i][widx-8]);
    return 32'h0;
  endfunction

  task automatic model_step();
    bit wr;
    int widx;
    wr   = req && we && (addr[1:0] == 2'b00);
    widx = int'(addr[7:2]);
    for (int i = 0; i < 2; i++) begin
      bit gate;
      gate = m_en[i][0] && !m_ovf[i][0];
      for (int n = 0; n < NC; n++) begin
        bit hit, can, clear;
        int nc;
        bit no;
        hit = (n == 0);
        for (int k = 0; k < EW; k++)
          if (n != 0 && int'(m_sel[i][n]) == k) hit = evt[k];
        can = gate && m_en[i][n] && hit && (n == 0 || i == 1 || !m_ovf[i][n]);
        nc = m_cnt[i][n];
        no = m_ovf[i][n];
        if (can) begin
          if (m_cnt[i][n] == MAXV) begin
            no = 1;
            nc = (n == 0 || i == 1) ? 0 : MAXV;
          end else nc = m_cnt[i][n] + 1;
        end
        if (wr && widx == n) begin
          clear = (n == 0) ? (!m_clr[i][n] && wdata[1]) : !wdata[1];
          if (clear) begin nc = 0; no = 0; end
          if (n == 0 && !wdata[2]) no = 0;
          m_en[i][n]  = wdata[2];
          m_clr[i][n] = wdata[1];
          m_sel[i][n] = wdata[31:24];
        end else if (n != 0) begin
          m_clr[i][n] = 1;
        end
        m_cnt[i][n] = nc;
        m_ovf[i][n] = no;
      end
    end
  endtask

  task automatic check(string rq, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h at %0t", rq, what, act, exp, $time);
    end
  endtask

  // compare mid-cycle, then advance the model with the edge
  task automatic tick();
    @(negedge clk);
    for (int i = 0; i < 2; i++) begin
      check(cur_req, $sformatf("u%0d irq", i), 32'(irq[i]), 32'(m_ovf[i][0]));
      check(cur_req, $sformatf("u%0d rdata @%h", i, addr), rdata[i], model_read(i));
    end
    @(posedge clk);
    model_step();
    #1;
  endtask

  task automatic idle(int cycles);
    for (int k = 0; k < cycles; k++) begin
      int p;
      p = scan_ptr % 8;
      scan_ptr++;
      req = 1; we = 0;
      addr = (p < 4) ? 8'(p * 4) : 8'(8'h20 + (p - 4) * 4);
      tick();
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    req = 1; we = 1; addr = a; wdata = d;
    tick();
    we = 0;
  endtask

  task automatic rd(logic [7:0] a);
    req = 1; we = 0; addr = a;
    tick();
  endtask

  task automatic nop();
    req = 0; we = 0;
    tick();
  endtask

  initial begin
    #(CLK_P * 100000);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    cur_req = "R1";
    check("R1", "irq after reset", 32'(irq[0] | irq[1]), 32'h0);
    rd(8'h00);
    check("R1", "ctrl0 reset word", rdata[0], 32'h0000_0002);
    idle(8);

    cur_req = "R2";
    rd(8'h10); rd(8'h30); rd(8'h3C); rd(8'hFC); rd(8'h21); rd(8'h02);
    nop(); nop();
    wr(8'h40, 32'hFFFF_FFFF);

    cur_req = "R3";
    wr(8'h04, 32'hABFF_FFFB);
    rd(8'h04);
    wr(8'h24, 32'h0000_1234);
    rd(8'h24);
    idle(4);

    cur_req = "R4";
    wr(8'h00, 32'h0000_0006);
    idle(20);

    cur_req = "R5";
    wr(8'h04, 32'h0300_0006);
    wr(8'h08, 32'h1400_0006);
    wr(8'h0C, 32'h0000_0006);
    for (int k = 0; k < 60; k++) begin
      evt = EW'($urandom);
      idle(1);
    end

    cur_req = "R6";
    wr(8'h00, 32'h0000_0004);
    idle(3);
    wr(8'h00, 32'h0000_0006);
    idle(4);
    wr(8'h00, 32'h0000_0006);
    idle(3);

    cur_req = "R7";
    wr(8'h04, 32'h0300_0004);
    rd(8'h04);
    rd(8'h04);
    idle(4);

    cur_req = "R12";
    evt = 16'h0008;
    idle(3);
    wr(8'h04, 32'h0300_0004);
    rd(8'h24);
    wr(8'h0C, 32'h0300_0006);
    rd(8'h2C);
    rd(8'h2C);

    cur_req = "R11";
    wr(8'h0C, 32'h0000_0006);
    for (int k = 0; k < 6; k++) begin
      wr(8'h00, 32'h0000_0004);
      wr(8'h00, 32'h0000_0006);
      idle(60);
    end
    rd(8'h04);
    rd(8'h24);
    wr(8'h04, 32'h0300_0004);
    idle(4);

    cur_req = "R8";
    evt = 16'h0009;
    idle(300);

    cur_req = "R9";
    idle(5);
    wr(8'h00, 32'h0000_0004);
    idle(3);
    wr(8'h00, 32'h0000_0006);
    idle(280);
    wr(8'h00, 32'h0000_0000);
    idle(3);

    cur_req = "R10";
    for (int k = 0; k < 10; k++) begin
      evt = ~evt;
      idle(1);
    end
    wr(8'h00, 32'h0000_0006);
    idle(10);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule